// File: doc/BRIEF.md
# Speech Transport Block Framer

This block packs two coded speech frames of 137 bits each into one fixed 480-bit transport block. It sends that block one bit at a time onto an 8 kbit/s serial sub-channel, so at that rate one block lasts 60 ms and each speech frame stands for 30 ms of audio.

Every block opens with a run of 24 zero bits and then a single one. A receiver uses this pattern to find block alignment. After the pattern come five control bits:
- three bits that say whether each sub-block carries speech, stolen signalling or a maintenance payload;
- two bad-frame flags, one for each sub-block.

The two frames follow the control bits, and the leftover positions are filled with ones. Every bit whose index is a multiple of 24, from index 24 onward, is forced to one. This means no payload content can produce a false 24-zero run.

A bit-enable strobe sets the pace of the output. New blocks are taken in only at a block boundary, through a valid/ready handshake. While no call is active, the line is held at one.

Top module: `sptx_block_framer`

## Requirements
- R1: While `call_active` is low, `ser_out` is 1 and `blk_start` is 0 from the next clock on. Dropping `call_active` in the middle of a block abandons that block.
- R2: While a call is active and no block is in progress, each bit-enable with `blk_valid` low emits a 1, and `blk_ready` stays high.
- R3: Bit indices 0 to 23 of a block are 0 and index 24 is 1. `blk_start` is high exactly while bit index 0 is on the line.
- R4: Indices 25 to 29 carry the control field in this order: `steal_code[2]`, `steal_code[1]`, `steal_code[0]`, `bfi_flags[0]` (sub-block 1 errored), `bfi_flags[1]` (sub-block 2 errored).
- R5: Every index that is a multiple of 24, from 24 up to 456, is 1, whatever the payload.
- R6: The remaining positions, taken in increasing index order, carry `frame_a[0]` to `frame_a[136]`, then `frame_b[0]` to `frame_b[136]`, then ones (spare).
- R7: `ser_out` changes only in the clock after a cycle in which `bit_en` was high, apart from reset and call release.
- R8: A block is accepted only on a bit-enable with `blk_valid` and `blk_ready` both high. `blk_ready` is low for the whole block, so `blk_valid` and frame data presented during a block have no effect on it.
- R9: A block is exactly 480 bits long. A block offered on the bit-enable that follows bit index 479 starts at once, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_active | input | 1 | High while a call uses the sub-channel |
| bit_en | input | 1 | Strobe; one output bit per high cycle |
| blk_valid | input | 1 | A new block is offered |
| frame_a | input | 137 | First speech frame, bit 0 sent first |
| frame_b | input | 137 | Second speech frame, bit 0 sent first |
| steal_code | input | 3 | Sub-block stealing code, MSB sent first |
| bfi_flags | input | 2 | Bad-frame flags: bit 0 sub-block 1, bit 1 sub-block 2 |
| blk_ready | output | 1 | Block boundary reached, call active, offer can be taken |
| ser_out | output | 1 | Serial line bit |
| blk_start | output | 1 | High while the first header bit is on the line |

## Verification
The bench compares every emitted bit of complete blocks with an arithmetic model of bit index to content. It uses three payload patterns, each of which separates different faults:
- Sparse mixed frames catch swapped frames and bit-order faults.
- All-zero frames expose any missing forced one or a header imitation.
- All-one frames show that no zero leaks out of the control or spare fields.

Garbage data with `blk_valid` held high during a block shows that offers in mid-block are ignored. A back-to-back offer checks the 480-bit length. An abort in mid-block followed by a fresh block checks the release to idle ones and a clean restart at the header.

// File: rtl/sptx_pkg.sv
package sptx_pkg;
  localparam int CTRL_W = 5;

  // Control field in transmit order: element 0 leaves first.
  function automatic logic [CTRL_W-1:0] pack_ctrl(input logic [2:0] steal,
                                                  input logic [1:0] bfi);
    return {bfi[1], bfi[0], steal[0], steal[1], steal[2]};
  endfunction
endpackage

// File: rtl/sptx_pos_tracker.sv
module sptx_pos_tracker #(
  parameter int BLK_BITS    = 480,
  parameter int HDR_ZEROS   = 24,
  parameter int SYNC_PERIOD = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic start,
  input  logic step,
  output logic busy,
  output logic in_hdr,
  output logic at_sync,
  output logic at_last
);
  localparam int POS_W = $clog2(BLK_BITS);
  localparam int PH_W  = $clog2(SYNC_PERIOD);

  logic [POS_W-1:0] pos_q;
  logic [PH_W-1:0]  ph_q;
  logic             busy_q;

  // Classification of the bit index about to be sent.
  assign in_hdr  = pos_q < POS_W'(HDR_ZEROS);
  assign at_sync = ph_q == '0;
  assign at_last = pos_q == POS_W'(BLK_BITS - 1);
  assign busy    = busy_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      ph_q   <= '0;
    end else if (start) begin
      // Index 0 goes out on the accepting strobe; index 1 comes next.
      busy_q <= 1'b1;
      pos_q  <= POS_W'(1);
      ph_q   <= PH_W'(1);
    end else if (step) begin
      if (at_last) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
        ph_q   <= '0;
      end else begin
        pos_q <= pos_q + POS_W'(1);
        ph_q  <= (ph_q == PH_W'(SYNC_PERIOD - 1)) ? '0 : ph_q + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/sptx_payload_shifter.sv
module sptx_payload_shifter #(
  parameter int FRAME_W = 137
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 shift,
  input  logic [FRAME_W-1:0]   frame_a,
  input  logic [FRAME_W-1:0]   frame_b,
  input  logic [2:0]           steal_code,
  input  logic [1:0]           bfi_flags,
  output logic                 head_bit
);
  import sptx_pkg::*;

  localparam int SH_W = CTRL_W + 2 * FRAME_W;

  logic [SH_W-1:0] sh_q;

  assign head_bit = sh_q[0];

  // Ones enter at the top, so slots past the two frames read as spare ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '1;
    end else if (load) begin
      sh_q <= {frame_b, frame_a, pack_ctrl(steal_code, bfi_flags)};
    end else if (shift) begin
      sh_q <= {1'b1, sh_q[SH_W-1:1]};
    end
  end
endmodule

// File: rtl/sptx_block_framer.sv
module sptx_block_framer #(
  parameter int FRAME_W     = 137,
  parameter int BLK_BITS    = 480,
  parameter int HDR_ZEROS   = 24,
  parameter int SYNC_PERIOD = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               call_active,
  input  logic               bit_en,
  input  logic               blk_valid,
  input  logic [FRAME_W-1:0] frame_a,
  input  logic [FRAME_W-1:0] frame_b,
  input  logic [2:0]         steal_code,
  input  logic [1:0]         bfi_flags,
  output logic               blk_ready,
  output logic               ser_out,
  output logic               blk_start
);
  logic busy, in_hdr, at_sync, at_last;
  logic accept, step, consume, head_bit;
  logic ser_q, start_q;

  assign blk_ready = call_active & ~busy;
  assign accept    = bit_en & blk_valid & blk_ready;
  assign step      = bit_en & busy & call_active;
  assign consume   = step & ~in_hdr & ~at_sync;

  sptx_pos_tracker #(
    .BLK_BITS   (BLK_BITS),
    .HDR_ZEROS  (HDR_ZEROS),
    .SYNC_PERIOD(SYNC_PERIOD)
  ) u_pos (
    .clk    (clk),
    .rst    (rst),
    .abort  (~call_active),
    .start  (accept),
    .step   (step),
    .busy   (busy),
    .in_hdr (in_hdr),
    .at_sync(at_sync),
    .at_last(at_last)
  );

  sptx_payload_shifter #(
    .FRAME_W(FRAME_W)
  ) u_pay (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .shift     (consume),
    .frame_a   (frame_a),
    .frame_b   (frame_b),
    .steal_code(steal_code),
    .bfi_flags (bfi_flags),
    .head_bit  (head_bit)
  );

  always_ff @(posedge clk) begin
    if (rst || !call_active) begin
      ser_q   <= 1'b1;
      start_q <= 1'b0;
    end else if (bit_en) begin
      if (accept) begin
        ser_q   <= 1'b0;
        start_q <= 1'b1;
      end else if (busy) begin
        ser_q   <= in_hdr ? 1'b0 : (at_sync ? 1'b1 : head_bit);
        start_q <= 1'b0;
      end else begin
        ser_q   <= 1'b1;
        start_q <= 1'b0;
      end
    end
  end

  assign ser_out   = ser_q;
  assign blk_start = start_q;
endmodule

// File: rtl/sptx_framer_checker.sv
module sptx_framer_checker (
  input logic clk,
  input logic rst,
  input logic call_active,
  input logic bit_en,
  input logic blk_valid,
  input logic blk_ready,
  input logic ser_out,
  input logic blk_start
);
  // R1: no call means an idle line of ones
  a_r1_idle_ones: assert property (@(posedge clk) disable iff (rst)
    !call_active |=> (ser_out && !blk_start));

  // R3: the flagged bit is the first header zero
  a_r3_start_is_zero: assert property (@(posedge clk) disable iff (rst)
    blk_start |-> !ser_out);

  // R7: no strobe, no change
  a_r7_paced_output: assert property (@(posedge clk) disable iff (rst)
    ($past(call_active) && !$past(bit_en) && !$past(rst)) |-> $stable(ser_out));

  // R8: a block in flight is not ready for another
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    blk_start |-> !blk_ready);

  // R8: a block only begins through the handshake
  a_r8_start_needs_handshake: assert property (@(posedge clk) disable iff (rst)
    $rose(blk_start) |-> $past(bit_en && blk_valid && blk_ready));
endmodule

bind sptx_block_framer sptx_framer_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .call_active(call_active),
  .bit_en     (bit_en),
  .blk_valid  (blk_valid),
  .blk_ready  (blk_ready),
  .ser_out    (ser_out),
  .blk_start  (blk_start)
);

// File: tb/tb_sptx_block_framer.sv
module tb_sptx_block_framer;
  localparam int FW  = 137;
  localparam int BLK = 480;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic call_active = 1'b0;
  logic bit_en = 1'b0;
  logic blk_valid = 1'b0;
  logic [FW-1:0] frame_a = '0;
  logic [FW-1:0] frame_b = '0;
  logic [2:0] steal_code = '0;
  logic [1:0] bfi_flags = '0;
  logic blk_ready, ser_out, blk_start;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  sptx_block_framer dut (
    .clk(clk), .rst(rst), .call_active(call_active), .bit_en(bit_en),
    .blk_valid(blk_valid), .frame_a(frame_a), .frame_b(frame_b),
    .steal_code(steal_code), .bfi_flags(bfi_flags),
    .blk_ready(blk_ready), .ser_out(ser_out), .blk_start(blk_start)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  // Index-to-content model built from the requirements.
  function automatic logic exp_bit(input int idx, input logic [FW-1:0] a,
                                   input logic [FW-1:0] b, input logic [2:0] st,
                                   input logic [1:0] bf);
    int s;
    if (idx < 24) return 1'b0;
    if (idx % 24 == 0) return 1'b1;
    s = idx - 25 - (idx / 24 - 1);
    case (s)
      0: return st[2];
      1: return st[1];
      2: return st[0];
      3: return bf[0];
      4: return bf[1];
      default: ;
    endcase
    s = s - 5;
    if (s < FW) return a[s];
    s = s - FW;
    if (s < FW) return b[s];
    return 1'b1;
  endfunction

  function automatic string req_of(input int idx);
    if (idx < 25) return "R3";
    if (idx < 30) return "R4";
    if (idx % 24 == 0) return "R5";
    return "R6";
  endfunction

  task automatic tick(output logic b, output logic s);
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    b = ser_out;
    s = blk_start;
  endtask

  // Sends a block and checks it for nbits bits. Garbage is offered during it (R8).
  task automatic run_block(input logic [FW-1:0] a, input logic [FW-1:0] b,
                           input logic [2:0] st, input logic [1:0] bf,
                           input int nbits, input bit gap);
    logic bo, so;
    frame_a = a; frame_b = b; steal_code = st; bfi_flags = bf; blk_valid = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      if (i == 200) chk(blk_ready, 1'b0, "R8", "ready mid block");
      tick(bo, so);
      if (i == 0) begin
        frame_a = ~a; frame_b = ~b; steal_code = ~st; bfi_flags = ~bf;
      end
      chk(bo, exp_bit(i, a, b, st, bf), req_of(i), $sformatf("bit %0d", i));
      chk(so, (i == 0), "R3", $sformatf("start flag at bit %0d", i));
      if (gap && i < 30) begin
        @(negedge clk);
        chk(ser_out, bo, "R7", $sformatf("hold after bit %0d", i));
      end
    end
  endtask

  logic [FW-1:0] pa, pb, zz, oo;
  logic bo, so;

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < FW; i++) begin
      pa[i] = (i % 3) == 0;
      pb[i] = ((i * 7) % 5) < 2;
    end
    zz = '0;
    oo = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ser_out, 1'b1, "R1", "reset line");
    chk(blk_start, 1'b0, "R1", "reset start flag");
    chk(blk_ready, 1'b0, "R1", "ready without call");

    // R1: strobes and offers without a call leave the line at one
    blk_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(bo, so);
      chk(bo, 1'b1, "R1", "no call line");
      chk(so, 1'b0, "R1", "no call start");
    end
    blk_valid = 1'b0;

    call_active = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      tick(bo, so);
      chk(bo, 1'b1, "R2", "idle in call");
      chk(blk_ready, 1'b1, "R2", "ready idle");
    end

    run_block(pa, pb, 3'b100, 2'b01, BLK, 1'b1);
    // R9: back-to-back start right after index 479
    run_block(zz, zz, 3'b011, 2'b10, BLK, 1'b0);
    run_block(oo, oo, 3'b111, 2'b11, BLK, 1'b0);
    blk_valid = 1'b0;
    tick(bo, so);
    chk(bo, 1'b1, "R9", "line after block end");
    chk(so, 1'b0, "R9", "no start after block end");
    chk(blk_ready, 1'b1, "R9", "ready after 480 bits");

    // R1: abort in mid block
    run_block(pb, pa, 3'b010, 2'b00, 100, 1'b0);
    call_active = 1'b0;
    blk_valid = 1'b0;
    @(negedge clk);
    chk(ser_out, 1'b1, "R1", "abort line");
    chk(blk_start, 1'b0, "R1", "abort start flag");
    call_active = 1'b1;
    @(negedge clk);
    chk(blk_ready, 1'b1, "R8", "ready after abort");
    for (int i = 0; i < 2; i++) begin
      tick(bo, so);
      chk(bo, 1'b1, "R2", "idle after abort");
    end
    run_block(pb, pa, 3'b101, 2'b10, BLK, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule